// File: doc/BRIEF.md
# Valley-Count Gate Drive Controller

This block drives the gate of a quasi-resonant flyback switch. Three comparator outputs come in: the zero-crossing sense above its low (50 mV) level, the same sense above its high (1 V) level, and the current ramp reaching the feedback level. A regulation counter outside the block supplies a 4-bit target valley count. The block counts falling crossings of the low level and turns the gate on in the valley whose number equals the target.

The gate turns off when the current ramp reaches the feedback level. Every turn-off clears the valley counter, so each switching period counts from zero. A ramp-driven turn-off also starts a blanking interval. During that interval the gate cannot turn on and crossings are not counted. The interval is short when the sense is above the high level at the moment it starts, and long otherwise. The level the sense takes later in the interval does not change its length.

Top module: `valley_gate_ctrl`

## Requirements
- R1: After synchronisation, each 1-to-0 transition of `senseLowRaw` adds one to the valley counter, unless blanking is active or the counter is being cleared.
- R2: While blanking is inactive and the synchronised `senseLowRaw` is 0, the gate goes high on the clock edge after the valley count equals a nonzero `targetCount`. Target 1 turns on at the first crossing and target 2 at the second.
- R3: The gate is driven low on the clock edge after the synchronised `senseLowRaw` is seen high.
- R4: The gate is driven low on the clock edge after the synchronised `rampHitRaw` is seen high while the gate is on, and this edge starts a blanking interval.
- R5: The blanking interval lasts `SHORT_CYCLES` clocks if the synchronised `senseHighRaw` is 1 when it starts, and `LONG_CYCLES` clocks otherwise. The gate cannot turn on during it.
- R6: `senseHighRaw` is sampled only when the interval starts. A change during the interval does not alter its length.
- R7: Every gate turn-off, whatever its cause, clears the valley counter to 0.
- R8: Falling crossings that arrive during blanking are not counted.
- R9: A `targetCount` of 0 keeps the gate low.
- R10: The valley counter saturates at 15 and does not wrap.
- R11: Each comparator input passes through a two-flop synchroniser. After reset the gate is low, the count is 0 and blanking is inactive. A falling crossing applied between clock edges raises the gate on the fourth rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| senseLowRaw | input | 1 | Comparator: zero-crossing sense above the low level (asynchronous) |
| senseHighRaw | input | 1 | Comparator: zero-crossing sense above the high level (asynchronous) |
| rampHitRaw | input | 1 | Comparator: current ramp has reached feedback (asynchronous) |
| targetCount | input | 4 | Valley number at which to turn on, from the regulation counter |
| gateOut | output | 1 | Gate drive, 1 = switch on |

## Verification
The assertions assume that the comparator inputs change rarely compared with the clock. Each level is assumed to hold for at least two clocks, so every transition survives the synchronisers as one clean edge. The stimulus holds each sense and ramp level for at least two clocks and changes `targetCount` only while the gate is low. The blanking checks place crossings well clear of the interval boundaries. Their outcome then depends only on which of the two lengths was chosen, not on a cycle of synchroniser delay.

// File: rtl/valley_pkg.sv
package valley_pkg;
  typedef struct packed {
    logic clrCount;
    logic startBlank;
  } vgStrobe_t;
endpackage

// File: rtl/vg_sync.sv
module vg_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else if (s == 0) stage[s] <= dIn;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dOut = stage[STAGES-1];
endmodule

// File: rtl/vg_datapath.sv
module vg_datapath
  import valley_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int SHORT_CYCLES = 750,
  parameter int LONG_CYCLES = 7500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             senseLowRaw,
  input  logic             senseHighRaw,
  input  logic             rampHitRaw,
  input  vgStrobe_t        strobe,
  output logic             senseLowS,
  output logic             rampHitS,
  output logic             blanking,
  output logic [CNT_W-1:0] valleyCount
);
  localparam int TMR_W = $clog2(LONG_CYCLES + 1);
  localparam logic [TMR_W-1:0] SHORT_LD = TMR_W'(SHORT_CYCLES);
  localparam logic [TMR_W-1:0] LONG_LD  = TMR_W'(LONG_CYCLES);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [2:0] syncOut;
  logic senseHighS, senseLowD, fallEdge;
  logic [TMR_W-1:0] blankTmr;

  vg_sync #(.WIDTH(3), .STAGES(2)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .dIn({rampHitRaw, senseHighRaw, senseLowRaw}),
    .dOut(syncOut)
  );

  assign senseLowS  = syncOut[0];
  assign senseHighS = syncOut[1];
  assign rampHitS   = syncOut[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) senseLowD <= 1'b0;
    else senseLowD <= senseLowS;
  end

  assign fallEdge = senseLowD & ~senseLowS;
  assign blanking = (blankTmr != '0);

  // valley counter: clear wins, blanked crossings dropped, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valleyCount <= '0;
    else if (strobe.clrCount) valleyCount <= '0;
    else if (fallEdge && !blanking && valleyCount != CNT_MAX)
      valleyCount <= valleyCount + 1'b1;
  end

  // blanking timer, length fixed by the high-level comparator at start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blankTmr <= '0;
    else if (strobe.startBlank) blankTmr <= senseHighS ? SHORT_LD : LONG_LD;
    else if (blanking) blankTmr <= blankTmr - 1'b1;
  end
endmodule

// File: rtl/vg_control.sv
module vg_control
  import valley_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             senseLowS,
  input  logic             rampHitS,
  input  logic             blanking,
  input  logic [CNT_W-1:0] valleyCount,
  input  logic [CNT_W-1:0] targetCount,
  output vgStrobe_t        strobe,
  output logic             gateOut
);
  logic gateNext, turnOn, turnOff;

  assign turnOn  = !gateOut && !blanking && !senseLowS &&
                   (targetCount != '0) && (valleyCount == targetCount);
  assign turnOff = gateOut && (senseLowS || rampHitS);

  always_comb begin
    gateNext = gateOut;
    if (turnOff) gateNext = 1'b0;
    else if (turnOn) gateNext = 1'b1;
    strobe.clrCount   = turnOff;
    strobe.startBlank = gateOut && rampHitS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gateOut <= 1'b0;
    else gateOut <= gateNext;
  end
endmodule

// File: rtl/valley_gate_ctrl.sv
module valley_gate_ctrl
  import valley_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int SHORT_CYCLES = 750,
  parameter int LONG_CYCLES = 7500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             senseLowRaw,
  input  logic             senseHighRaw,
  input  logic             rampHitRaw,
  input  logic [CNT_W-1:0] targetCount,
  output logic             gateOut
);
  vgStrobe_t strobe;
  logic senseLowS, rampHitS, blanking;
  logic [CNT_W-1:0] valleyCount;

  vg_datapath #(.CNT_W(CNT_W), .SHORT_CYCLES(SHORT_CYCLES), .LONG_CYCLES(LONG_CYCLES)) i_dp (
    .clk(clk), .rst_n(rst_n),
    .senseLowRaw(senseLowRaw), .senseHighRaw(senseHighRaw), .rampHitRaw(rampHitRaw),
    .strobe(strobe), .senseLowS(senseLowS), .rampHitS(rampHitS),
    .blanking(blanking), .valleyCount(valleyCount)
  );

  vg_control #(.CNT_W(CNT_W)) i_ctl (
    .clk(clk), .rst_n(rst_n),
    .senseLowS(senseLowS), .rampHitS(rampHitS), .blanking(blanking),
    .valleyCount(valleyCount), .targetCount(targetCount),
    .strobe(strobe), .gateOut(gateOut)
  );
endmodule

// File: rtl/valley_gate_ctrl_checker.sv
module valley_gate_ctrl_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gateOut,
  input logic             senseLowS,
  input logic             rampHitS,
  input logic             blanking,
  input logic [CNT_W-1:0] valleyCount,
  input logic [CNT_W-1:0] targetCount
);
  p_sense_forces_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    senseLowS |=> !gateOut);

  p_ramp_turns_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gateOut && rampHitS) |=> (!gateOut && blanking));

  p_no_on_in_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (blanking && !gateOut) |=> !gateOut);

  p_on_at_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gateOut) |-> ($past(valleyCount) == $past(targetCount)));

  p_clear_on_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gateOut) |-> (valleyCount == '0));

  p_zero_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (targetCount == '0 && !gateOut) |=> !gateOut);

  p_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valleyCount == '1) |=> (valleyCount == '1 || valleyCount == '0));

  p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(valleyCount) |-> (valleyCount == '0 ||
                               valleyCount == $past(valleyCount) + 1'b1));
endmodule

bind valley_gate_ctrl valley_gate_ctrl_checker #(.CNT_W(CNT_W)) i_checker (
  .clk(clk), .rst_n(rst_n), .gateOut(gateOut), .senseLowS(senseLowS),
  .rampHitS(rampHitS), .blanking(blanking), .valleyCount(valleyCount),
  .targetCount(targetCount)
);

// File: tb/test_valley_gate_ctrl.sv
module test_valley_gate_ctrl;
  localparam int SHORT = 40;
  localparam int LONG  = 300;
  localparam int NV = 10;
  localparam int V_TGT [NV] = '{1, 2, 2, 3, 0, 5, 15, 2, 4, 1};
  localparam int V_N   [NV] = '{1, 1, 2, 3, 5, 4, 15, 3, 8, 2};
  localparam int V_EXP [NV] = '{1, 0, 1, 1, 0, 0, 1,  0, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic senseLowRaw = 1'b0, senseHighRaw = 1'b0, rampHitRaw = 1'b0;
  logic [3:0] targetCount = 4'd0;
  logic gateOut;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  valley_gate_ctrl #(.CNT_W(4), .SHORT_CYCLES(SHORT), .LONG_CYCLES(LONG)) i_valley_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .senseLowRaw(senseLowRaw), .senseHighRaw(senseHighRaw),
    .rampHitRaw(rampHitRaw), .targetCount(targetCount), .gateOut(gateOut)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: gateOut=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic valley(input int hi, input int lo);
    senseLowRaw = 1'b1; tick(hi);
    senseLowRaw = 1'b0; tick(lo);
  endtask

  task automatic doReset();
    rst_n = 1'b0; senseLowRaw = 0; senseHighRaw = 0; rampHitRaw = 0;
    tick(3); rst_n = 1'b1; tick(2);
  endtask

  task automatic rampOff(input logic hiLevel);
    senseHighRaw = hiLevel; tick(4);
    rampHitRaw = 1'b1; tick(2);
    senseHighRaw = ~hiLevel;  // R6: later change must not matter
    tick(1); rampHitRaw = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    doReset();
    check(gateOut, 1'b0, "R11 reset state");

    // vector table: R1 R2 R9
    for (int v = 0; v < NV; v++) begin
      doReset();
      targetCount = 4'(V_TGT[v]);
      tick(2);
      for (int k = 0; k < V_N[v]; k++) valley(4, 4);
      tick(4);
      check(gateOut, 1'(V_EXP[v]), $sformatf("R1/R2/R9 vector %0d", v));
    end

    // R11: exact synchroniser latency
    doReset(); targetCount = 4'd1; tick(2);
    valley(4, 3);
    check(gateOut, 1'b0, "R11 latency, before 4th edge");
    tick(1);
    check(gateOut, 1'b1, "R11 latency, after 4th edge");

    // R3: sense above low level forces gate off
    senseLowRaw = 1'b1; tick(4);
    check(gateOut, 1'b0, "R3 forced low");
    senseLowRaw = 1'b0; tick(6);
    check(gateOut, 1'b1, "R3 resume after crossing");

    // R4, R5 short, R6, R8
    rampOff(1'b1);
    tick(3);
    check(gateOut, 1'b0, "R4 ramp turn-off");
    valley(2, 2);           // inside blanking: ignored
    tick(50);
    check(gateOut, 1'b0, "R8 crossing during blanking ignored");
    valley(4, 6);
    check(gateOut, 1'b1, "R5/R6 short interval elapsed");

    // R5 long
    rampOff(1'b0);
    tick(80);
    valley(4, 6);
    check(gateOut, 1'b0, "R5 long interval still blanking");
    tick(300);
    valley(4, 6);
    check(gateOut, 1'b1, "R5 long interval elapsed");

    // R7: counter cleared on turn-off
    doReset(); targetCount = 4'd2; tick(2);
    valley(4, 4); valley(4, 6);
    check(gateOut, 1'b1, "R7 on at second valley");
    rampOff(1'b1); tick(60);
    valley(4, 6);
    check(gateOut, 1'b0, "R7 counting from zero after off");
    valley(4, 6);
    check(gateOut, 1'b1, "R7 on after two new valleys");

    // R10: saturation at 15
    doReset(); targetCount = 4'd0; tick(2);
    for (int k = 0; k < 17; k++) valley(3, 3);
    check(gateOut, 1'b0, "R9 target zero held off");
    targetCount = 4'd15; tick(4);
    check(gateOut, 1'b1, "R10 counter saturated at 15");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule